// File: doc/BRIEF.md
# Pipelined Eight-Point Inverse Integer Transform

This block performs one dimension of the 8x8 inverse integer transform used when video residuals are rebuilt from dequantised coefficients. Eight signed coefficients arrive together in every clock cycle. Eight signed results leave together four cycles later. A new vector can enter in every cycle. A separable 2-D transform uses the block twice: once over rows and once over columns, with a transpose buffer outside the block between the two passes. Dequantisation, the final rounding, clipping and the transpose storage all belong to the surrounding logic.

The arithmetic is a factored network built only from additions, subtractions and arithmetic right shifts by one or two bits. No multiplier is used. The first stage forms partial sums. The second stage finishes the even and odd intermediates. The third stage cross-couples the odd terms with quarter-weight shifts. The fourth stage is a mirrored butterfly that produces the results. One pass costs 32 add/subtract operations and 10 shifts. The reordering of lanes at the input and output is plain wiring.

Top module: `iit8_core`

## Requirements
- R1: In the cycle after any clock edge sampled with `rst_n` low, `out_valid` is 0 and every lane of `out_res` is 0.
- R2: `out_valid` equals the `in_valid` sampled four rising edges earlier. The results for a vector appear in that same cycle.
- R3: A vector may be presented in every cycle. Back-to-back vectors yield back-to-back, independent results.
- R4: The even intermediates are computed as follows, with shifts arithmetic and rounding toward minus infinity:
  - p=x0+x4 and q=x0-x4
  - r=(x2>>>1)-x6 and s=x2+(x6>>>1)
  - the even terms are e0=p+s, e1=q+r, e2=q-r, e3=p-s
- R5: The odd intermediates are computed as follows:
  - u1=x5-x3-x7-(x7>>>1)
  - u3=x1+x7-x3-(x3>>>1)
  - u5=x7-x1+x5+(x5>>>1)
  - u7=x3+x5+x1+(x1>>>1)
  - the odd terms are o0=u7-(u1>>>2), o1=(u3>>>2)-u5, o2=u3+(u5>>>2), o3=u1+(u7>>>2)
- R6: The output stage is a mirrored butterfly: y[k]=e_k+o_k and y[7-k]=e_k-o_k for k=0..3. Lane k of a bus occupies bits [k*W +: W], where W is the lane width.
- R7: Every shift floors negative values. For example, x2=-1 alone gives y = (-1,-1,1,1,1,1,-1,-1).
- R8: A vector whose only nonzero coefficient is x0=d gives d in all eight output lanes.
- R9: An all-zero vector gives all-zero results.
- R10: The outputs are IN_W+4 bits wide. With every input at the most positive or the most negative value, no intermediate or result wraps.
- R11: The datapath advances every cycle whatever the value of `in_valid`. Inputs presented with `in_valid` low still produce their results four cycles later, marked not valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Marks the input vector as meaningful |
| in_coef | input | 8*IN_W | Eight signed coefficients; lane k at [k*IN_W +: IN_W] |
| out_valid | output | 1 | Valid flag delayed by four cycles |
| out_res | output | 8*(IN_W+4) | Eight signed results; lane k at [k*(IN_W+4) +: IN_W+4] |

## Verification
Two things can land in the same cycle. The first is reset arriving while all four stages hold live vectors. The bench fills the pipeline with valid random vectors and then asserts reset. It then requires zero data and a low valid flag from the very next cycle, with no stale result leaking out. The second is a new vector being captured in the same cycle as the previous one is retired. Long runs of back-to-back random vectors, with `in_valid` patterns that mix runs and bubbles, are compared every clock against a behavioural model. A leak or a swap between neighbouring vectors shows up as a mismatch at the cycle where it happens.

// File: rtl/iit8_pkg.sv
// Shared constants of the eight-point inverse transform.
// Assumes: the pipeline depth is fixed by the structure of the network.
package iit8_pkg;
    localparam int PIPE_DEPTH = 4;   // register stages from input to output
    localparam int GUARD_BITS = 4;   // growth bits above the input width
    localparam int LANES      = 8;   // points per vector
endpackage

// File: rtl/iit8_even.sv
// Even half of the network: lanes 0,2,4,6 in, four even terms out after
// three register stages (the third only aligns with the odd half).
// Assumes inputs are already sign-extended to the working width W.
module iit8_even #(
    parameter int W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] x0,
    input  logic signed [W-1:0] x2,
    input  logic signed [W-1:0] x4,
    input  logic signed [W-1:0] x6,
    output logic signed [W-1:0] e0,
    output logic signed [W-1:0] e1,
    output logic signed [W-1:0] e2,
    output logic signed [W-1:0] e3
);
    logic signed [W-1:0] p_q, q_q, r_q, s_q;
    logic signed [W-1:0] t0_q, t1_q, t2_q, t3_q;

    // Stage 1: sum/difference of lanes 0,4 and half-weighted pair 2,6.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {p_q, q_q, r_q, s_q} <= '0;
        end else begin
            p_q <= x0 + x4;
            q_q <= x0 - x4;
            r_q <= (x2 >>> 1) - x6;
            s_q <= x2 + (x6 >>> 1);
        end
    end

    // Stage 2: combine into the four even terms.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {t0_q, t1_q, t2_q, t3_q} <= '0;
        end else begin
            t0_q <= p_q + s_q;
            t1_q <= q_q + r_q;
            t2_q <= q_q - r_q;
            t3_q <= p_q - s_q;
        end
    end

    // Stage 3: delay to match the odd half.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {e0, e1, e2, e3} <= '0;
        end else begin
            e0 <= t0_q;
            e1 <= t1_q;
            e2 <= t2_q;
            e3 <= t3_q;
        end
    end
endmodule

// File: rtl/iit8_odd.sv
// Odd half of the network: lanes 1,3,5,7 in, four odd terms out after
// three register stages. Uses x + x/2 for the 3/2 weights and
// quarter-weight shifts for the cross coupling.
// Assumes inputs are already sign-extended to the working width W.
module iit8_odd #(
    parameter int W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] x1,
    input  logic signed [W-1:0] x3,
    input  logic signed [W-1:0] x5,
    input  logic signed [W-1:0] x7,
    output logic signed [W-1:0] o0,
    output logic signed [W-1:0] o1,
    output logic signed [W-1:0] o2,
    output logic signed [W-1:0] o3
);
    logic signed [W-1:0] m1_q, m3_q, m5_q, m7_q;   // pair sums
    logic signed [W-1:0] h1_q, h3_q, h5_q, h7_q;   // 3/2-weighted lanes
    logic signed [W-1:0] u1_q, u3_q, u5_q, u7_q;

    // Stage 1: pair sums and 3/2-weighted single lanes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {m1_q, m3_q, m5_q, m7_q} <= '0;
            {h1_q, h3_q, h5_q, h7_q} <= '0;
        end else begin
            m1_q <= x5 - x3;
            m3_q <= x1 + x7;
            m5_q <= x7 - x1;
            m7_q <= x3 + x5;
            h1_q <= x7 + (x7 >>> 1);
            h3_q <= x3 + (x3 >>> 1);
            h5_q <= x5 + (x5 >>> 1);
            h7_q <= x1 + (x1 >>> 1);
        end
    end

    // Stage 2: complete the four odd intermediates.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {u1_q, u3_q, u5_q, u7_q} <= '0;
        end else begin
            u1_q <= m1_q - h1_q;
            u3_q <= m3_q - h3_q;
            u5_q <= m5_q + h5_q;
            u7_q <= m7_q + h7_q;
        end
    end

    // Stage 3: quarter-weight cross coupling, ordered for the butterfly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {o0, o1, o2, o3} <= '0;
        end else begin
            o0 <= u7_q - (u1_q >>> 2);
            o1 <= (u3_q >>> 2) - u5_q;
            o2 <= u3_q + (u5_q >>> 2);
            o3 <= u1_q + (u7_q >>> 2);
        end
    end
endmodule

// File: rtl/iit8_bfly.sv
// Mirrored output butterfly: y[k] = ev[k] + od[k], y[7-k] = ev[k] - od[k].
// One register stage. Assumes W already carries the growth bits.
module iit8_bfly #(
    parameter int W = 20
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic signed [W-1:0] ev [4],
    input  logic signed [W-1:0] od [4],
    output logic signed [W-1:0] y  [8]
);
    for (genvar k = 0; k < 4; k++) begin : g_pair
        // Sum lane k and difference lane 7-k of one butterfly pair.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                y[k]     <= '0;
                y[7 - k] <= '0;
            end else begin
                y[k]     <= ev[k] + od[k];
                y[7 - k] <= ev[k] - od[k];
            end
        end
    end
endmodule

// File: rtl/iit8_core.sv
// One-dimensional eight-point inverse integer transform, four-stage
// pipeline, one vector per cycle. Data advances every cycle; in_valid
// only travels alongside. Assumes the caller handles dequantisation,
// transposition and final rounding/clipping.
module iit8_core #(
    parameter int IN_W  = 16,
    parameter int GUARD = iit8_pkg::GUARD_BITS
) (
    input  logic                                  clk,
    input  logic                                  rst_n,
    input  logic                                  in_valid,
    input  logic [iit8_pkg::LANES*IN_W-1:0]       in_coef,
    output logic                                  out_valid,
    output logic [iit8_pkg::LANES*(IN_W+GUARD)-1:0] out_res
);
    localparam int OUT_W = IN_W + GUARD;
    localparam int N     = iit8_pkg::LANES;
    localparam int DEPTH = iit8_pkg::PIPE_DEPTH;

    logic signed [OUT_W-1:0] xw [N];
    logic signed [OUT_W-1:0] ev [4];
    logic signed [OUT_W-1:0] od [4];
    logic signed [OUT_W-1:0] yw [N];
    logic [DEPTH-1:0]        vld_q;

    // Split the input bus into sign-extended lanes and pack the results.
    for (genvar k = 0; k < N; k++) begin : g_lane
        assign xw[k] = OUT_W'($signed(in_coef[k*IN_W +: IN_W]));
        assign out_res[k*OUT_W +: OUT_W] = yw[k];
    end

    iit8_even #(.W(OUT_W)) u_even (
        .clk(clk), .rst_n(rst_n),
        .x0(xw[0]), .x2(xw[2]), .x4(xw[4]), .x6(xw[6]),
        .e0(ev[0]), .e1(ev[1]), .e2(ev[2]), .e3(ev[3])
    );

    iit8_odd #(.W(OUT_W)) u_odd (
        .clk(clk), .rst_n(rst_n),
        .x1(xw[1]), .x3(xw[3]), .x5(xw[5]), .x7(xw[7]),
        .o0(od[0]), .o1(od[1]), .o2(od[2]), .o3(od[3])
    );

    iit8_bfly #(.W(OUT_W)) u_bfly (
        .clk(clk), .rst_n(rst_n),
        .ev(ev), .od(od), .y(yw)
    );

    // Valid flag shift register matching the data latency.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= {vld_q[DEPTH-2:0], in_valid};
    end

    assign out_valid = vld_q[DEPTH-1];
endmodule

// File: rtl/iit8_chk.sv
// Assertion checker for iit8_core: keeps its own short history of the
// inputs and relates it to the outputs four cycles later.
module iit8_chk #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 20
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [8*IN_W-1:0]     in_coef,
    input logic                  out_valid,
    input logic [8*OUT_W-1:0]    out_res
);
    localparam int D = iit8_pkg::PIPE_DEPTH;

    logic [D-1:0]            v_hist, z_hist, dc_hist;
    logic signed [IN_W-1:0]  dc_val [D];
    logic signed [OUT_W-1:0] dc_ext;
    logic                    dc_ok;

    // History of valid, all-zero and only-lane-0 conditions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_hist  <= '0;
            z_hist  <= '0;
            dc_hist <= '0;
            for (int i = 0; i < D; i++) dc_val[i] <= '0;
        end else begin
            v_hist  <= {v_hist[D-2:0], in_valid};
            z_hist  <= {z_hist[D-2:0], (in_coef == '0)};
            dc_hist <= {dc_hist[D-2:0], (in_coef[8*IN_W-1:IN_W] == '0)};
            dc_val[0] <= $signed(in_coef[IN_W-1:0]);
            for (int i = 1; i < D; i++) dc_val[i] <= dc_val[i-1];
        end
    end

    assign dc_ext = OUT_W'(dc_val[D-1]);

    // All eight lanes equal the delayed lane-0 value.
    always_comb begin
        dc_ok = 1'b1;
        for (int k = 0; k < 8; k++)
            if ($signed(out_res[k*OUT_W +: OUT_W]) != dc_ext) dc_ok = 1'b0;
    end

    assert_reset_clears_R1: assert property (@(posedge clk)
        !rst_n |=> (!out_valid && out_res == '0));

    assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == v_hist[D-1]);

    assert_dc_spread_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dc_hist[D-1] |-> dc_ok);

    assert_zero_in_zero_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
        z_hist[D-1] |-> (out_res == '0));
endmodule

bind iit8_core iit8_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_coef(in_coef),
    .out_valid(out_valid), .out_res(out_res)
);

// File: tb/iit8_core_tb.sv
// Bench: behavioural model of the transform equations, a queue standing
// in for the latency, comparison on every clock at the falling edge.
module iit8_core_tb;
    localparam int IW = 16;
    localparam int OW = IW + 4;
    localparam int LAT = 4;

    typedef struct packed {
        logic             vld;
        logic [7:0][31:0] y;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [8*IW-1:0] in_coef = '0;
    logic            out_valid;
    logic [8*OW-1:0] out_res;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    iit8_core #(.IN_W(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_coef(in_coef),
        .out_valid(out_valid), .out_res(out_res)
    );

    // Reference equations written directly from the requirements.
    function automatic void ref8(input int x[8], output int y[8]);
        int p, q, r, s, e[4], u1, u3, u5, u7, o[4];
        p = x[0] + x[4];
        q = x[0] - x[4];
        r = (x[2] >>> 1) - x[6];
        s = x[2] + (x[6] >>> 1);
        e[0] = p + s; e[1] = q + r; e[2] = q - r; e[3] = p - s;
        u1 = x[5] - x[3] - x[7] - (x[7] >>> 1);
        u3 = x[1] + x[7] - x[3] - (x[3] >>> 1);
        u5 = x[7] - x[1] + x[5] + (x[5] >>> 1);
        u7 = x[3] + x[5] + x[1] + (x[1] >>> 1);
        o[0] = u7 - (u1 >>> 2);
        o[1] = (u3 >>> 2) - u5;
        o[2] = u3 + (u5 >>> 2);
        o[3] = u1 + (u7 >>> 2);
        for (int k = 0; k < 4; k++) begin
            y[k]     = e[k] + o[k];
            y[7 - k] = e[k] - o[k];
        end
    endfunction

    function automatic int rnd();
        logic signed [IW-1:0] v;
        v = IW'($urandom);
        return int'(v);
    endfunction

    // One cycle: compare outputs with the entry due now, then drive new input.
    task automatic step(input string tag, input logic vld, input int xv[8]);
        exp_t e, n;
        int   yv[8];
        int   got;
        bit   bad;
        @(negedge clk);
        e   = exp_q.pop_front();
        bad = 1'b0;
        n_checks++;
        if (out_valid !== e.vld) begin
            bad = 1'b1;
            $display("FAIL %s out_valid actual=%b expected=%b", tag, out_valid, e.vld);
        end
        for (int k = 0; k < 8; k++) begin
            got = int'($signed(out_res[k*OW +: OW]));
            if (got != $signed(e.y[k])) begin
                bad = 1'b1;
                $display("FAIL %s lane %0d actual=%0d expected=%0d",
                         tag, k, got, $signed(e.y[k]));
            end
        end
        if (bad) n_fails++;
        ref8(xv, yv);
        n.vld = vld;
        for (int k = 0; k < 8; k++) n.y[k] = yv[k];
        exp_q.push_back(n);
        in_valid = vld;
        for (int k = 0; k < 8; k++) in_coef[k*IW +: IW] = xv[k][IW-1:0];
    endtask

    // Reset for a few cycles; the model restarts with an empty pipeline.
    task automatic do_reset();
        exp_t z;
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b0;
        in_coef = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        exp_q.delete();
        z = '0;
        for (int i = 0; i < LAT; i++) exp_q.push_back(z);
    endtask

    task automatic flush(input string tag);
        int zv[8] = '{default: 0};
        for (int i = 0; i < LAT; i++) step(tag, 1'b0, zv);
    endtask

    initial begin
        int xv[8];
        do_reset();
        // R1: outputs are zero straight after reset.
        flush("R1");

        // R4: even lanes only.
        xv = '{100, 0, 55, 0, -37, 0, -9, 0};   step("R4", 1'b1, xv);
        xv = '{-321, 0, 77, 0, 12, 0, 1001, 0}; step("R4", 1'b1, xv);
        // R5: odd lanes only.
        xv = '{0, 40, 0, -13, 0, 7, 0, 99};     step("R5", 1'b1, xv);
        xv = '{0, -500, 0, 3, 0, -71, 0, 250};  step("R5", 1'b1, xv);
        // R6: single-lane impulses through the mirrored butterfly.
        for (int k = 0; k < 8; k++) begin
            xv = '{default: 0}; xv[k] = 64;
            step("R6", 1'b1, xv);
        end
        // R7: small negatives where flooring shifts matter.
        xv = '{0, 0, -1, 0, 0, 0, 0, 0};        step("R7", 1'b1, xv);
        xv = '{0, -1, 0, 0, 0, -1, -3, 0};      step("R7", 1'b1, xv);
        xv = '{0, 0, 0, -1, 0, 0, 0, -1};       step("R7", 1'b1, xv);
        // R8: lane 0 only.
        xv = '{-500, 0, 0, 0, 0, 0, 0, 0};      step("R8", 1'b1, xv);
        xv = '{1234, 0, 0, 0, 0, 0, 0, 0};      step("R8", 1'b1, xv);
        // R9: all zero.
        xv = '{default: 0};                     step("R9", 1'b1, xv);
        // R10: extreme inputs.
        xv = '{default: 32767};                 step("R10", 1'b1, xv);
        xv = '{default: -32768};                step("R10", 1'b1, xv);
        xv = '{32767, -32768, 32767, -32768, 32767, -32768, 32767, -32768};
        step("R10", 1'b1, xv);
        xv = '{32767, 32767, -32768, -32768, 32767, 32767, -32768, -32768};
        step("R10", 1'b1, xv);
        xv = '{-32768, 32767, 32767, 32767, -32768, 32767, -32768, -32768};
        step("R10", 1'b1, xv);
        // R3: back-to-back random vectors.
        for (int i = 0; i < 60; i++) begin
            foreach (xv[k]) xv[k] = rnd();
            step("R3", 1'b1, xv);
        end
        // R11: data still flows with in_valid low.
        for (int i = 0; i < 12; i++) begin
            foreach (xv[k]) xv[k] = rnd();
            step("R11", 1'b0, xv);
        end
        // R2: mixed valid pattern with bubbles.
        for (int i = 0; i < 40; i++) begin
            foreach (xv[k]) xv[k] = rnd();
            step("R2", ($urandom % 3) != 0, xv);
        end
        flush("R2");
        // R1: reset landing on a full pipeline of valid vectors.
        for (int i = 0; i < LAT; i++) begin
            foreach (xv[k]) xv[k] = rnd();
            step("R3", 1'b1, xv);
        end
        do_reset();
        flush("R1");
        for (int i = 0; i < 20; i++) begin
            foreach (xv[k]) xv[k] = rnd();
            step("R3", 1'b1, xv);
        end
        flush("R3");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end
endmodule